// File: doc/BRIEF.md
# Multi-Waveform DDS Sample Generator

This block is a direct digital synthesis source for a 12-bit serial voltage DAC. It keeps a phase accumulator that moves forward by a tuning word once per completed DAC frame. From the new phase it forms a sine, a sawtooth or a triangle sample. It scales that sample to a programmable peak-to-peak amplitude and adds a programmable offset. Both settings are given in millivolt codes. The sum is clamped to the DAC code range.

The serial shifter that feeds the DAC raises a one-cycle frame-done strobe at the end of each frame. That strobe is the only event that moves the phase or changes the output. As a result, the sample the shifter loads next stays steady for the whole following frame. The output frequency is f = tune_word × f_frame / 2^32. With a 50 MHz clock and a 29-cycle frame, this covers 10 Hz to 20 kHz with a resolution well below 1 mHz.

Top module: `dds_wavegen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the phase is cleared to zero and `sample` takes the value of `ofs_mv`.
- R2: At each edge with `frame_done` high, the phase becomes phase + `tune_word` modulo 2^32. At every other edge the phase is unchanged.
- R3: `sample` changes only at an edge where `frame_done` is high. Input changes between strobes have no effect on it until the next strobe.
- R4: `wave_sel` selects the waveform: 0 = sine, 1 = sawtooth, 2 = triangle, 3 = flat midscale (2048). With select 3, `sample` equals `ofs_mv` for any amplitude.
- R5: The sawtooth value is bits 31..20 of the updated phase.
- R6: The triangle value is built from t = bits 31..19 of the updated phase. When bit 12 of t is clear, the value is t[11:0]. When it is set, the value is 4095 − t[11:0].
- R7: The sine value is indexed by bits 31..22 of the updated phase. It lies within 5 codes of 2048 + 2047·sin(2π·idx/1024). Entries idx and idx+512 sum to exactly 4096, entries idx and 512−idx are equal, idx 0 gives 2048, idx 256 gives 4095 and idx 768 gives 1.
- R8: The output is ofs_mv + floor((wave − 2048) × amp_mv / 4096), where amp_mv = 4096 is unity gain. An amplitude of 0 yields `ofs_mv`.
- R9: A result below 0 outputs 0 and a result above 4095 outputs 4095. The value never wraps.
- R10: The output period is 2^32 / tune_word strobes. For example, a tuning word of 2^29 makes the sawtooth repeat every 8 strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_done | input | 1 | One-cycle pulse at the end of each DAC frame |
| tune_word | input | 32 | Phase increment per frame |
| wave_sel | input | 2 | Waveform select (0 sine, 1 saw, 2 triangle, 3 flat) |
| amp_mv | input | 13 | Amplitude scale, 4096 = full DAC span |
| ofs_mv | input | 12 | Offset in 1 mV codes |
| sample | output | 12 | Straight-binary DAC code, held between strobes |

## Verification
Sawtooth at unity gain exposes the raw phase. Tuning words of 2^29 and 0xF0000000 tell a correct modulo add and period apart from a wrong bit slice or a missing carry wrap. A 2^28 triangle places samples on both sides of the fold, and so separates a correct fold from an off-by-one fold. A full 1024-step sine sweep checks shape tolerance and both symmetry rules. Scaled, clamped, zero-amplitude and flat-select runs, with settings changed in the middle of a frame, separate the arithmetic from the timing of the update.

// File: rtl/dds_wavegen.sv
module dds_wavegen #(
  parameter int PHASE_W = 32,
  parameter int LUT_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  input  logic [PHASE_W-1:0] tune_word,
  input  logic [1:0]         wave_sel,
  input  logic [12:0]        amp_mv,
  input  logic [11:0]        ofs_mv,
  output logic [11:0]        sample
);
  localparam int SW   = 12;
  localparam int HALF = 1 << (LUT_W - 1);
  localparam int MID  = 1 << (SW - 1);
  localparam int TOP  = (1 << SW) - 1;

  // rational sine approximation over one half period, p in 0..HALF-1
  function automatic logic [SW-2:0] half_sin(input int p);
    int n, d;
    n = 4 * p * (HALF - p);
    d = (5 * HALF * HALF) / 4 - p * (HALF - p);
    return (SW-1)'((2047 * n + d / 2) / d);
  endfunction

  logic [SW-2:0] htab [0:HALF-1];
  for (genvar g = 0; g < HALF; g++) begin : g_tab
    assign htab[g] = half_sin(g);
  end

  logic [PHASE_W-1:0] phase;
  wire  [PHASE_W-1:0] phase_nx = phase + tune_word;

  wire [LUT_W-1:0] sidx = phase_nx[PHASE_W-1 -: LUT_W];
  wire [SW-2:0]    smag = htab[sidx[LUT_W-2:0]];
  wire [SW-1:0]    sine = sidx[LUT_W-1] ? SW'(MID) - {1'b0, smag} : SW'(MID) + {1'b0, smag};
  wire [SW-1:0]    saw  = phase_nx[PHASE_W-1 -: SW];
  wire [SW:0]      tfull = phase_nx[PHASE_W-1 -: SW+1];
  wire [SW-1:0]    tri_w = tfull[SW] ? ~tfull[SW-1:0] : tfull[SW-1:0];

  logic [SW-1:0] wave;
  always_comb begin
    case (wave_sel)
      2'd0:    wave = sine;
      2'd1:    wave = saw;
      2'd2:    wave = tri_w;
      default: wave = SW'(MID);
    endcase
  end

  wire signed [13:0] cen  = $signed({2'b0, wave}) - 14'sd2048;
  wire signed [27:0] prod = cen * $signed({1'b0, amp_mv});
  wire signed [15:0] dv   = 16'(prod >>> 12);
  wire signed [16:0] sum  = $signed({5'b0, ofs_mv}) + 17'(dv);
  wire [SW-1:0] clamped = (sum < 0) ? '0 : (sum > TOP) ? SW'(TOP) : sum[SW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      sample <= ofs_mv;
    end else if (frame_done) begin
      phase  <= phase_nx;
      sample <= clamped;
    end
  end
endmodule

// File: rtl/dds_wavegen_chk.sv
module dds_wavegen_chk #(
  parameter int PHASE_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_done,
  input logic [PHASE_W-1:0] tune_word,
  input logic [1:0]         wave_sel,
  input logic [12:0]        amp_mv,
  input logic [11:0]        ofs_mv,
  input logic [11:0]        sample,
  input logic [PHASE_W-1:0] phase
);
  logic [1:0] rcnt = 2'd0;
  always_ff @(posedge clk)
    if (!rst_n && rcnt != 2'd3) rcnt <= rcnt + 2'd1;
  wire live = (rcnt == 2'd3);

  logic [PHASE_W-1:0] nxt;
  assign nxt = phase + tune_word;

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n || !live)
    frame_done |=> phase == $past(phase) + $past(tune_word));

  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || !live)
    !frame_done |=> $stable(phase));

  assert_sample_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !live)
    !frame_done |=> $stable(sample));

  assert_flat_sel_R4: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (frame_done && wave_sel == 2'd3) |=> sample == $past(ofs_mv));

  assert_unity_saw_R5: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (frame_done && wave_sel == 2'd1 && amp_mv == 13'd4096 && ofs_mv == 12'd2048)
      |=> sample == $past(nxt[PHASE_W-1 -: 12]));

  assert_zero_amp_R8: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (frame_done && amp_mv == 13'd0) |=> sample == $past(ofs_mv));
endmodule

bind dds_wavegen dds_wavegen_chk #(.PHASE_W(PHASE_W)) u_chk (.*);

// File: tb/dds_wavegen_test.sv
`timescale 1ns/1ps
module dds_wavegen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [31:0] ftw = '0;
  logic [1:0]  sel = 2'd1;
  logic [12:0] amp = 13'd4096;
  logic [11:0] ofs = 12'd1500;
  logic [11:0] sample;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;
  string cur_req = "R1";
  bit [31:0] m_ph = '0;
  int  m_exp = 0;
  bit  m_sine = 0;

  always #10 clk = ~clk;

  dds_wavegen uut (.clk(clk), .rst_n(rst_n), .frame_done(strobe), .tune_word(ftw),
                   .wave_sel(sel), .amp_mv(amp), .ofs_mv(ofs), .sample(sample));

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(bit [31:0] ph, bit [1:0] s, int a, int o);
    int w, v, t;
    case (s)
      2'd0: w = $rtoi(2048.0 + 2047.0 * $sin(6.283185307179586 * real'(ph >> 22) / 1024.0) + 0.5);
      2'd1: w = int'(ph >> 20);
      2'd2: begin t = int'(ph >> 19); w = (t >= 4096) ? 4095 - (t - 4096) : t; end
      default: w = 2048;
    endcase
    v = o + (((w - 2048) * a) >>> 12);
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = '0; m_exp = int'(ofs); m_sine = 0;
    end else if (strobe) begin
      m_ph = m_ph + ftw;
      m_exp = model(m_ph, sel, int'(amp), int'(ofs));
      m_sine = (sel == 2'd0);
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      if (m_sine)
        check((int'(sample) - m_exp <= 5) && (m_exp - int'(sample) <= 5), "R7 model", int'(sample), m_exp);
      else
        check(int'(sample) == m_exp, cur_req, int'(sample), m_exp);
    end
  end

  task automatic frame();
    repeat (28) @(negedge clk);
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(sample == ofs, "R1 reset value", int'(sample), int'(ofs));
    rst_n = 1'b1;
  endtask

  task automatic setup(bit [1:0] s, bit [31:0] f, int a, int o);
    sel = s; ftw = f; amp = 13'(a); ofs = 12'(o);
    do_reset();
  endtask

  int sv [0:1023];
  int tv [0:16];
  int v0;
  bit hit_hi, hit_lo;

  initial begin
    // R1
    setup(2'd1, 32'h2000_0000, 4096, 1500);
    cmp_on = 1;
    // R5, R10, R3
    setup(2'd1, 32'h2000_0000, 4096, 2048);
    cur_req = "R5";
    frame();
    check(sample == 12'd512, "R5 first saw step", int'(sample), 512);
    v0 = int'(sample);
    for (int k = 0; k < 7; k++) begin
      frame();
      check(int'(sample) != v0, "R10 no early repeat", int'(sample), -1);
    end
    frame();
    check(int'(sample) == v0, "R10 period 8 strobes", int'(sample), v0);
    repeat (10) @(negedge clk);
    amp = 13'd100; ofs = 12'd300; sel = 2'd2;
    repeat (5) @(negedge clk);
    check(int'(sample) == v0, "R3 hold mid-frame", int'(sample), v0);
    cur_req = "R3";
    frame();
    // R2 wrap
    setup(2'd1, 32'hF000_0000, 4096, 2048);
    cur_req = "R2";
    frame();
    check(sample == 12'd3840, "R2 first step", int'(sample), 3840);
    frame();
    check(sample == 12'd3584, "R2 modulo wrap", int'(sample), 3584);
    // R6
    setup(2'd2, 32'h1000_0000, 4096, 2048);
    cur_req = "R6";
    for (int k = 1; k <= 16; k++) begin frame(); tv[k] = int'(sample); end
    check(tv[8] == 4095, "R6 fold peak", tv[8], 4095);
    for (int j = 1; j < 8; j++)
      check(tv[8 + j] == tv[8 - j] - 1, "R6 symmetry", tv[8 + j], tv[8 - j] - 1);
    // R7
    setup(2'd0, 32'h0040_0000, 4096, 2048);
    for (int k = 1; k <= 1024; k++) begin frame(); sv[k % 1024] = int'(sample); end
    check(sv[0] == 2048, "R7 idx 0", sv[0], 2048);
    check(sv[256] == 4095, "R7 idx 256", sv[256], 4095);
    check(sv[768] == 1, "R7 idx 768", sv[768], 1);
    for (int i = 0; i < 512; i++)
      check(sv[i] + sv[i + 512] == 4096, "R7 half symmetry", sv[i] + sv[i + 512], 4096);
    for (int i = 1; i < 256; i++)
      check(sv[i] == sv[512 - i], "R7 quarter mirror", sv[i], sv[512 - i]);
    // R8 scaling
    setup(2'd1, 32'h0123_4567, 3000, 2500);
    cur_req = "R8";
    repeat (40) frame();
    sel = 2'd2; ftw = 32'h0765_4321; amp = 13'd1234; ofs = 12'd1800;
    repeat (40) frame();
    setup(2'd2, 32'h0abc_def0, 0, 777);
    frame();
    check(sample == 12'd777, "R8 zero amplitude", int'(sample), 777);
    // R4 flat select
    setup(2'd3, 32'h1234_5678, 4096, 3100);
    cur_req = "R4";
    repeat (3) frame();
    check(sample == 12'd3100, "R4 flat select", int'(sample), 3100);
    // R9 clamp
    setup(2'd1, 32'h1000_0000, 8191, 3500);
    cur_req = "R9";
    hit_hi = 0; hit_lo = 0;
    for (int k = 0; k < 16; k++) begin
      frame();
      if (sample == 12'd4095) hit_hi = 1;
      if (sample == 12'd0) hit_lo = 1;
    end
    check(hit_hi, "R9 upper rail", int'(hit_hi), 1);
    check(hit_lo, "R9 lower rail", int'(hit_lo), 1);
    cmp_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule